// File: doc/BRIEF.md
# Multi-Mode 16-Bit Reloadable Timer Channel

This block is one channel of a bank of general-purpose timers. One 16-bit counter is backed by a reload register that software fills with two byte writes. An 8-bit mode register picks how that counter is used. It can be a free-running periodic timer, with an optional level gate on the external pin. It can count events from the external pin or from a neighbouring channel's overflow. It can run once and stop at zero. It can also act as a pulse-width generator with a fixed period of 65536 counts.

Outside the event mode, the count rate comes from one of four prescaled clock enables that the surrounding chip supplies. Each time the counter wraps it raises a one-cycle overflow strobe. Other channels can chain on that strobe, so several channels can be connected in a ring. The output pin carries a toggle that flips on every wrap, or the pulse-width waveform in PWM mode.

Mode register layout (bits): [1:0] mode (00 periodic, 01 event, 10 one-shot, 11 PWM); [2] gate enable; [3] polarity; [5:4] event source (00 pin edge, 01 previous channel, 10 next channel, 11 auxiliary timer); [7:6] clock-enable select.

Top module: `tmr16_channel`

## Requirements
- R1: After reset the reload value is 0, the mode register is 0x00 (periodic mode), and both `out_pin` and `ovf_pulse` are 0.
- R2: A write with `rld_wr`=1 stores `wr_data` into the low reload byte when `rld_hi`=0 and into the high byte when `rld_hi`=1. A rising edge of `start` copies the reload value into the counter (0xFFFF in PWM mode) and clears the output toggle.
- R3: The counter changes only while `start` is 1. With `start` at 0 it holds its value, and no overflow occurs.
- R4: In periodic mode each count tick decrements the counter. A tick at 0 reloads the counter, gives an overflow, and flips `out_pin`. The period is therefore (reload+1) ticks, and `up_dn` has no effect.
- R5: Outside event mode a count tick is `ce_src[k]`, where k is mode bits [7:6].
- R6: In periodic mode with bit 2 set, ticks count only while `ext_in` XOR bit 3 equals 1.
- R7: In event mode bits [5:4] pick the tick source. 00 is an `ext_in` edge (rising when bit 3=0, falling when bit 3=1), 01 is `ovf_prev`, 10 is `ovf_next` and 11 is `ovf_aux`. Sources that are not selected are ignored.
- R8: In event mode `up_dn`=1 counts up and `up_dn`=0 counts down. An up-count from 0xFFFF or a down-count from 0 reloads the counter and gives an overflow.
- R9: In one-shot mode the counter decrements to 0, raises one overflow and flips `out_pin` on reaching 0, and then stays at 0 until the next rising edge of `start`.
- R10: In PWM mode the period is 65536 ticks. `out_pin` is high for the first `reload` ticks of each period and low for the rest. The reload value is latched at each period start, and an overflow marks each period end. A reload of 0 keeps `out_pin` low.
- R11: `ovf_pulse` lasts exactly one clock per wrap and comes only from a count tick that occurred while `start` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rld_wr | input | 1 | Reload byte write strobe |
| rld_hi | input | 1 | Byte lane select: 0 low, 1 high |
| wr_data | input | 8 | Reload byte data |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register data |
| start | input | 1 | Count start flag |
| up_dn | input | 1 | Event-mode direction, 1 = up |
| ce_src | input | 4 | Prescaled clock enables, index 0..3 |
| ext_in | input | 1 | External input pin |
| ovf_prev | input | 1 | Overflow strobe from previous channel |
| ovf_next | input | 1 | Overflow strobe from next channel |
| ovf_aux | input | 1 | Overflow strobe from auxiliary timer |
| out_pin | output | 1 | Toggle or PWM output |
| ovf_pulse | output | 1 | One-cycle overflow strobe |

## Verification
Periodic mode is driven with two reload values and two clock-enable rates. The measured spacing between strobes separates an off-by-one in the reload from a wrong enable index. Event mode is fed edge trains on the pin with both polarities, and pulse trains on one neighbour line while another neighbour line is also active. This separates edge detection from level counting and shows that each source is selected on its own. Long random runs mix all four modes, gate settings, sources and directions against a cycle model. One full PWM period and a zero-duty run confirm the high-phase length and the period boundary.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    parameter int unsigned TMR_W  = 16;
    parameter int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        MD_TIMER   = 2'b00,
        MD_EVENT   = 2'b01,
        MD_ONESHOT = 2'b10,
        MD_PWM     = 2'b11
    } tmr_mode_e;

    // Packed in register bit order, MSB first
    typedef struct packed {
        logic [1:0] cks;    // [7:6] clock-enable select
        logic [1:0] esrc;   // [5:4] event source
        logic       pol;    // [3]   polarity
        logic       gate;   // [2]   gate enable
        tmr_mode_e  mode;   // [1:0] operating mode
    } mode_fields_t;

endpackage

// File: rtl/tmr16_regs.sv
module tmr16_regs
    import tmr16_pkg::*;
#(
    parameter int unsigned W      = TMR_W,
    parameter int unsigned BW     = BYTE_W,
    parameter int unsigned NLANE  = W / BW,
    parameter int unsigned LANE_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rld_wr,
    input  logic [LANE_W-1:0] rld_lane,
    input  logic [BW-1:0]     wr_data,
    input  logic              mode_wr,
    input  logic [7:0]        mode_wdata,
    output logic [W-1:0]      reload_o,
    output mode_fields_t      mode_o
);

    typedef struct packed {
        logic [W-1:0] reload;
        mode_fields_t mode;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NLANE; i++) begin
            if (rld_wr && (rld_lane == LANE_W'(i))) begin
                st_d.reload[i*BW +: BW] = wr_data;
            end
        end
        if (mode_wr) begin
            st_d.mode = mode_fields_t'(mode_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_o = st_q.reload;
    assign mode_o   = st_q.mode;

endmodule

// File: rtl/tmr16_srcsel.sv
module tmr16_srcsel
    import tmr16_pkg::*;
#(
    parameter int unsigned CKS_W = 2,
    parameter int unsigned NCK   = 1 << CKS_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  mode_fields_t   mode_f,
    input  logic [NCK-1:0] ce_src,
    input  logic           ext_in,
    input  logic           ovf_prev,
    input  logic           ovf_next,
    input  logic           ovf_aux,
    output logic           tick
);

    typedef struct packed {
        logic ext;
    } src_t;

    src_t st_d, st_q;
    logic edge_hit;
    logic evt_hit;
    logic gate_ok;
    logic ce_hit;

    always_comb begin
        st_d.ext = ext_in;
        edge_hit = mode_f.pol ? (!ext_in && st_q.ext) : (ext_in && !st_q.ext);
        case (mode_f.esrc)
            2'b00:   evt_hit = edge_hit;
            2'b01:   evt_hit = ovf_prev;
            2'b10:   evt_hit = ovf_next;
            default: evt_hit = ovf_aux;
        endcase
        gate_ok = !mode_f.gate || (ext_in ^ mode_f.pol);
        ce_hit  = ce_src[mode_f.cks];
        if (mode_f.mode == MD_EVENT) begin
            tick = evt_hit;
        end else if (mode_f.mode == MD_TIMER) begin
            tick = ce_hit && gate_ok;
        end else begin
            tick = ce_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int unsigned W = TMR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] reload,
    input  logic         start,
    input  logic         up_dn,
    input  logic         tick,
    output logic [W-1:0] cnt_o,
    output logic         start_q_o,
    output logic         out_o,
    output logic         ovf_o
);

    localparam logic [W-1:0] ALL1 = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] duty;
        logic         start;
        logic         tog;
        logic         out;
        logic         ovf;
    } core_t;

    core_t st_d, st_q;
    logic  wrap;
    logic  rise;

    always_comb begin
        st_d       = st_q;
        st_d.start = start;
        st_d.ovf   = 1'b0;
        wrap       = 1'b0;
        rise       = start && !st_q.start;
        if (rise) begin
            st_d.cnt  = (mode == MD_PWM) ? ALL1 : reload;
            st_d.duty = reload;
            st_d.tog  = 1'b0;
        end else if (start && tick) begin
            case (mode)
                MD_EVENT: begin
                    if (up_dn) begin
                        if (st_q.cnt == ALL1) begin
                            st_d.cnt = reload;
                            wrap     = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end else if (st_q.cnt == '0) begin
                        st_d.cnt = reload;
                        wrap     = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                MD_ONESHOT: begin
                    if (st_q.cnt != '0) begin
                        st_d.cnt = st_q.cnt - ONE;
                        wrap     = (st_q.cnt == ONE);
                    end
                end
                MD_PWM: begin
                    if (st_q.cnt == '0) begin
                        st_d.cnt  = ALL1;
                        st_d.duty = reload;
                        wrap      = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                default: begin
                    if (st_q.cnt == '0) begin
                        st_d.cnt = reload;
                        wrap     = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
            endcase
        end
        if (wrap) begin
            st_d.ovf = 1'b1;
            st_d.tog = !st_q.tog;
        end
        if (mode == MD_PWM) begin
            st_d.out = start && ((~st_d.cnt) < st_d.duty);
        end else begin
            st_d.out = st_d.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign start_q_o = st_q.start;
    assign out_o     = st_q.out;
    assign ovf_o     = st_q.ovf;

endmodule

// File: rtl/tmr16_channel.sv
module tmr16_channel
    import tmr16_pkg::*;
#(
    parameter int unsigned CNT_W = TMR_W,
    parameter int unsigned LN_W  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rld_wr,
    input  logic            rld_hi,
    input  logic [LN_W-1:0] wr_data,
    input  logic            mode_wr,
    input  logic [7:0]      mode_wdata,
    input  logic            start,
    input  logic            up_dn,
    input  logic [3:0]      ce_src,
    input  logic            ext_in,
    input  logic            ovf_prev,
    input  logic            ovf_next,
    input  logic            ovf_aux,
    output logic            out_pin,
    output logic            ovf_pulse
);

    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    mode_fields_t     mode_f;
    tmr_mode_e        cur_mode;
    logic             tick;
    logic             start_q;

    assign cur_mode = mode_f.mode;

    tmr16_regs #(.W(CNT_W), .BW(LN_W), .NLANE(2), .LANE_W(1)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rld_wr     (rld_wr),
        .rld_lane   (rld_hi),
        .wr_data    (wr_data),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .reload_o   (reload),
        .mode_o     (mode_f)
    );

    tmr16_srcsel #(.CKS_W(2)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_f   (mode_f),
        .ce_src   (ce_src),
        .ext_in   (ext_in),
        .ovf_prev (ovf_prev),
        .ovf_next (ovf_next),
        .ovf_aux  (ovf_aux),
        .tick     (tick)
    );

    tmr16_core #(.W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (cur_mode),
        .reload    (reload),
        .start     (start),
        .up_dn     (up_dn),
        .tick      (tick),
        .cnt_o     (cnt),
        .start_q_o (start_q),
        .out_o     (out_pin),
        .ovf_o     (ovf_pulse)
    );

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk
    import tmr16_pkg::*;
#(
    parameter int unsigned W = TMR_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         start_q,
    input logic         up_dn,
    input tmr_mode_e    mode,
    input logic [W-1:0] reload,
    input logic [W-1:0] cnt,
    input logic         tick,
    input logic         ovf
);

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(cnt)); // R3

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !start_q && mode != MD_PWM) |=> (cnt == $past(reload))); // R2

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_q && tick && mode != MD_EVENT && cnt != '0)
        |=> (cnt == W'($past(cnt) - 1'b1))); // R4

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_q && tick && mode == MD_EVENT && up_dn && cnt != {W{1'b1}})
        |=> (cnt == W'($past(cnt) + 1'b1))); // R8

    AST_ONESHOT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_ONESHOT && cnt == '0 && !(start && !start_q)) |=> (cnt == '0)); // R9

    AST_OVF_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ($past(tick) && $past(start))); // R11

endmodule

bind tmr16_channel tmr16_chk #(.W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .start_q (start_q),
    .up_dn   (up_dn),
    .mode    (cur_mode),
    .reload  (reload),
    .cnt     (cnt),
    .tick    (tick),
    .ovf     (ovf_pulse)
);

// File: tb/sim_tmr16_channel.sv
`timescale 1ns/1ps
module sim_tmr16_channel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rld_wr = 1'b0, rld_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic       start = 1'b0, up_dn = 1'b0;
    logic [3:0] ce_src;
    logic       ext_in = 1'b0, ovf_prev = 1'b0, ovf_next = 1'b0, ovf_aux = 1'b0;
    logic       out_pin, ovf_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int cyc = 0;
    int n_ovf = 0, n_hi = 0, last_ovf = 0, prev_ovf = 0;
    logic [5:0] div_cnt = '0;

    always #4 clk = ~clk;

    assign ce_src = {div_cnt == 6'd0, div_cnt[4:0] == 5'd0, div_cnt[2:0] == 3'd0, 1'b1};

    tmr16_channel u0 (
        .clk(clk), .rst_n(rst_n), .rld_wr(rld_wr), .rld_hi(rld_hi), .wr_data(wr_data),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .start(start), .up_dn(up_dn),
        .ce_src(ce_src), .ext_in(ext_in), .ovf_prev(ovf_prev), .ovf_next(ovf_next),
        .ovf_aux(ovf_aux), .out_pin(out_pin), .ovf_pulse(ovf_pulse)
    );

    // ---------------- reference model built from the requirements ----------------
    logic [15:0] rm_reload, rm_cnt, rm_duty;
    logic [7:0]  rm_mode;
    logic        rm_startq, rm_extq, rm_tog, rm_out, rm_ovf;

    function automatic bit f_tick(input logic [7:0] m, input logic [3:0] ce, input logic e,
                                  input logic eq, input logic pv, input logic nx, input logic ax);
        bit edge_hit;
        edge_hit = m[3] ? (!e && eq) : (e && !eq);
        if (m[1:0] == 2'b01) begin
            case (m[5:4])
                2'b00:   return edge_hit;
                2'b01:   return pv;
                2'b10:   return nx;
                default: return ax;
            endcase
        end
        return ce[m[7:6]] && (m[1:0] != 2'b00 || !m[2] || (e ^ m[3]));
    endfunction

    function automatic string f_req(input logic [1:0] m);
        case (m)
            2'b00:   return "R4";
            2'b01:   return "R8";
            2'b10:   return "R9";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rm_reload <= '0; rm_cnt <= '0; rm_duty <= '0; rm_mode <= '0;
            rm_startq <= 1'b0; rm_extq <= 1'b0; rm_tog <= 1'b0; rm_out <= 1'b0; rm_ovf <= 1'b0;
        end else begin : model_step
            logic [15:0] nr, nc, nd;
            logic nt, nw, tk;
            nr = rm_reload;
            if (rld_wr) begin
                if (rld_hi) nr[15:8] = wr_data; else nr[7:0] = wr_data;
            end
            tk = f_tick(rm_mode, ce_src, ext_in, rm_extq, ovf_prev, ovf_next, ovf_aux);
            nc = rm_cnt; nd = rm_duty; nt = rm_tog; nw = 1'b0;
            if (start && !rm_startq) begin
                nc = (rm_mode[1:0] == 2'b11) ? 16'hFFFF : rm_reload;
                nd = rm_reload; nt = 1'b0;
            end else if (start && tk) begin
                case (rm_mode[1:0])
                    2'b01: begin
                        if (up_dn) begin
                            if (rm_cnt == 16'hFFFF) begin nc = rm_reload; nw = 1'b1; end
                            else nc = rm_cnt + 16'd1;
                        end else if (rm_cnt == 16'd0) begin nc = rm_reload; nw = 1'b1; end
                        else nc = rm_cnt - 16'd1;
                    end
                    2'b10: if (rm_cnt != 16'd0) begin nc = rm_cnt - 16'd1; nw = (rm_cnt == 16'd1); end
                    2'b11: begin
                        if (rm_cnt == 16'd0) begin nc = 16'hFFFF; nd = rm_reload; nw = 1'b1; end
                        else nc = rm_cnt - 16'd1;
                    end
                    default: begin
                        if (rm_cnt == 16'd0) begin nc = rm_reload; nw = 1'b1; end
                        else nc = rm_cnt - 16'd1;
                    end
                endcase
            end
            if (nw) nt = !rm_tog;
            rm_out    <= (rm_mode[1:0] == 2'b11) ? (start && ((~nc) < nd)) : nt;
            rm_reload <= nr;
            rm_mode   <= mode_wr ? mode_wdata : rm_mode;
            rm_cnt <= nc; rm_duty <= nd; rm_tog <= nt; rm_ovf <= nw;
            rm_startq <= start; rm_extq <= ext_in;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // negedge monitor: counters and per-cycle model comparison
    always @(negedge clk) begin
        cyc++;
        div_cnt <= div_cnt + 6'd1;
        if (rst_n) begin
            if (ovf_pulse) begin prev_ovf = last_ovf; last_ovf = cyc; n_ovf++; end
            if (out_pin) n_hi++;
            chk(f_req(rm_mode[1:0]), "out_pin vs model", int'(out_pin), int'(rm_out));
            chk("R11", "ovf_pulse vs model", int'(ovf_pulse), int'(rm_ovf));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reload(input logic [15:0] v);
        rld_wr = 1'b1; rld_hi = 1'b0; wr_data = v[7:0]; step(1);
        rld_hi = 1'b1; wr_data = v[15:8]; step(1);
        rld_wr = 1'b0; rld_hi = 1'b0;
    endtask

    task automatic wr_mode(input logic [7:0] m);
        mode_wr = 1'b1; mode_wdata = m; step(1);
        mode_wr = 1'b0;
    endtask

    task automatic setup(input logic [7:0] m, input logic [15:0] r);
        start = 1'b0; step(2);
        wr_mode(m); wr_reload(r);
        start = 1'b1; step(1);
    endtask

    task automatic pulses(input int k, input bit on_pin, input bit on_prev, input bit on_next);
        for (int i = 0; i < k; i++) begin
            if (on_pin) ext_in = 1'b1;
            ovf_prev = on_prev; ovf_next = on_next; step(1);
            ovf_prev = 1'b0; ovf_next = 1'b0; step(1);
            if (on_pin) ext_in = 1'b0;
            step(2);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int base_o, base_h, seed;
        seed = 32'h5eed_71a3;
        void'($urandom(seed));
        step(3);
        // R1: reset state
        chk("R1", "out_pin at reset", int'(out_pin), 0);
        chk("R1", "ovf_pulse at reset", int'(ovf_pulse), 0);
        rst_n = 1'b1; step(2);
        chk("R1", "out_pin after reset", int'(out_pin), 0);

        // R2/R4: periodic mode, reload 5 written bytewise, up_dn ignored
        up_dn = 1'b1;
        setup(8'h00, 16'h0005);
        step(40);
        chk("R4", "periodic spacing reload 5", last_ovf - prev_ovf, 6);
        // R2: high byte lands in upper lane (0x0100 -> period 257)
        setup(8'h00, 16'h0100);
        step(600);
        chk("R2", "periodic spacing reload 0x0100", last_ovf - prev_ovf, 257);

        // R5: clock-enable select index 1 (every 8) and 2 (every 32)
        setup(8'h40, 16'h0005);
        step(200);
        chk("R5", "spacing with enable 1", last_ovf - prev_ovf, 48);
        setup(8'h80, 16'h0001);
        step(300);
        chk("R5", "spacing with enable 2", last_ovf - prev_ovf, 64);

        // R3: stopping freezes counting
        setup(8'h00, 16'h0003);
        step(20);
        start = 1'b0; step(2);
        base_o = n_ovf; step(100);
        chk("R3", "overflows while stopped", n_ovf - base_o, 0);

        // R6: gate, active high then active low
        ext_in = 1'b0;
        setup(8'h04, 16'h0005);
        base_o = n_ovf; step(100);
        chk("R6", "gated off overflows", n_ovf - base_o, 0);
        ext_in = 1'b1; step(60);
        chk("R6", "gated on spacing", last_ovf - prev_ovf, 6);
        setup(8'h0C, 16'h0005);
        base_o = n_ovf; step(100);
        chk("R6", "active-low gate held off", n_ovf - base_o, 0);
        ext_in = 1'b0; step(2);

        // R7: pin edges, rising then falling; 8 edges with reload 3 down -> 2 wraps
        up_dn = 1'b0;
        setup(8'h01, 16'h0003);
        step(2); base_o = n_ovf;
        pulses(8, 1'b1, 1'b0, 1'b0);
        chk("R7", "rising pin edges wraps", n_ovf - base_o, 2);
        setup(8'h09, 16'h0003);
        step(2); base_o = n_ovf;
        pulses(8, 1'b1, 1'b0, 1'b0);
        chk("R7", "falling pin edges wraps", n_ovf - base_o, 2);

        // R8/R7: up-count chained on next channel, previous channel ignored
        up_dn = 1'b1;
        setup(8'h21, 16'hFFFC);
        step(2); base_o = n_ovf;
        pulses(10, 1'b0, 1'b0, 1'b1);
        chk("R8", "up-count wraps from next", n_ovf - base_o, 2);
        base_o = n_ovf;
        pulses(10, 1'b0, 1'b1, 1'b0);
        chk("R7", "unselected previous ignored", n_ovf - base_o, 0);
        up_dn = 1'b0;

        // R9: one-shot
        setup(8'h02, 16'h0004);
        base_o = n_ovf; step(50);
        chk("R9", "one-shot single overflow", n_ovf - base_o, 1);
        chk("R9", "one-shot output flipped", int'(out_pin), 1);
        base_o = n_ovf; step(50);
        chk("R9", "one-shot stays stopped", n_ovf - base_o, 0);

        // R10: PWM duty 10 over one full period
        start = 1'b0; step(2);
        wr_mode(8'h03); wr_reload(16'd10);
        start = 1'b1;
        base_o = n_ovf; base_h = n_hi;
        step(65536);
        chk("R10", "high count per period", n_hi - base_h, 10);
        chk("R10", "no overflow inside period", n_ovf - base_o, 0);
        step(2);
        chk("R10", "overflow at period end", n_ovf - base_o, 1);
        setup(8'h03, 16'h0000);
        base_h = n_hi; step(500);
        chk("R10", "zero duty stays low", n_hi - base_h, 0);

        // random phase, compared each cycle against the model
        for (int it = 0; it < 40; it++) begin
            logic [7:0] m;
            m = 8'($urandom());
            up_dn = 1'($urandom());
            setup(m, 16'($urandom_range(0, 40)));
            for (int c = 0; c < 300; c++) begin
                ext_in = 1'($urandom()); ovf_prev = 1'($urandom());
                ovf_next = 1'($urandom()); ovf_aux = 1'($urandom());
                step(1);
            end
        end
        ovf_prev = 1'b0; ovf_next = 1'b0; ovf_aux = 1'b0;
        step(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule